// File: doc/BRIEF.md
# Elastic Byte Buffer with Clock Steering

This block takes a byte stream that arrives on a write clock, gated by a clock enable and a valid strobe, and plays it out as a serial bit stream on a separate line clock. The line clock comes from an external oscillator. The block helps keep that oscillator at the right rate: the number of bytes in the 32-entry buffer is compared against two programmable marks. When too much is stored, it asks for a faster clock. When too little is stored, it asks for a slower one. In this way the buffer fill serves as the phase detector of a loop whose filter and oscillator lie outside the block.

Write and read pointers pass between the two clock domains as Gray codes through two-flop synchronizers. A write into a full buffer and a byte boundary with nothing left to send are both recorded in a sticky corruption flag. The flag is cleared only by reset. An enable input freezes the serial side and holds its output low.

Top module: `elastic_fifo_steer`

## Requirements
- R1: The buffer stores at most 32 bytes. A write that the write side sees as full is dropped, and the stored data is unchanged.
- R2: Each stored byte is sent most significant bit first, one bit per rising read-clock edge. The next byte is taken only after all 8 bits of the current byte have been presented. Bytes that are available follow each other with no gap.
- R3: When a byte finishes and no byte is available, the serial output is 0 until data arrives. The finishing edge with an empty buffer is an underflow.
- R4: While `enable` is 0, `ser_out`, `vco_up` and `vco_down` are 0 and nothing is read. Disabling discards the partly sent byte. After re-enable, sending resumes with the next stored byte.
- R5: The fill seen on the read side is the synchronized write count minus the read count. `vco_up` is 1 when this fill is strictly greater than `hi_mark`.
- R6: `vco_down` is 1 when the read-side fill is strictly less than `lo_mark`.
- R7: When both conditions hold, only `vco_down` is asserted. The two steering outputs are never high together.
- R8: An overflow (R1) or an underflow (R3) sets `fifo_corrupt`.
- R9: `fifo_corrupt` stays set until reset. Reset clears it, and reset also empties the buffer.
- R10: A byte is written only on a write-clock edge where both `wr_clk_en` and `wr_valid` are 1.
- R11: Each domain sees the other's pointer through two flops. A write therefore becomes visible to the read side after the second read edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_clk_en | input | 1 | Write-side clock enable |
| wr_valid | input | 1 | Byte present on wr_data |
| wr_data | input | 8 | Incoming byte |
| rd_clk | input | 1 | Line (serial) clock from the external oscillator |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| enable | input | 1 | Read-side run enable |
| hi_mark | input | 5 | Fill threshold for the faster-clock request |
| lo_mark | input | 5 | Fill threshold for the slower-clock request |
| ser_out | output | 1 | Serial bit stream |
| vco_up | output | 1 | Request a faster line clock |
| vco_down | output | 1 | Request a slower line clock |
| fifo_corrupt | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench exercises the block with four input patterns:
- A burst that writes on every edge while the block is disabled. This shows that writes are accepted but nothing is sent.
- A sparse one-in-twelve write rate against the one-in-eight drain. This empties the buffer, asserts the slower-clock request, and produces idle gaps and an underflow.
- A one-in-three write rate with valid dropouts. This fills the buffer past the high mark into overflow, and is followed by a drain with no writes to show that the flag stays set.
- Marks that overlap, which check the priority rule, and an enable toggled in the middle of a byte, which checks the discard-and-resume behaviour.

// File: rtl/elastic_fifo_steer.sv
module elastic_fifo_steer #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int MW = 5
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_clk_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          enable,
  input  logic [MW-1:0] hi_mark,
  input  logic [MW-1:0] lo_mark,
  output logic          ser_out,
  output logic          vco_up,
  output logic          vco_down,
  output logic          fifo_corrupt
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int BCW   = $clog2(DW) + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wptr, wgray, rptr, rgray;
  logic [PW-1:0]  wg_s1, wg_s2, rg_s1, rg_s2;
  logic [DW-1:0]  sh;
  logic [BCW-1:0] cnt;
  logic           ovf, udf;

  wire [PW-1:0] rsync = gray2bin(rg_s2);
  wire [PW-1:0] wsync = gray2bin(wg_s2);
  wire [PW-1:0] wnext = wptr + 1'b1;
  wire [PW-1:0] rnext = rptr + 1'b1;
  wire          push  = wr_clk_en && wr_valid;
  wire          full  = (wptr - rsync) == PW'(DEPTH);
  wire          empty = (wsync == rptr);
  wire [PW-1:0] fill  = wsync - rptr;
  wire          below = fill < PW'(lo_mark);
  wire          above = fill > PW'(hi_mark);

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (push) begin
        if (full) ovf <= 1'b1;
        else begin
          wptr  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end
    end

  always_ff @(posedge wr_clk)
    if (push && !full) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      sh    <= '0;
      cnt   <= '0;
      udf   <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (!enable) begin
        sh  <= '0;
        cnt <= '0;
      end else if (cnt > BCW'(1)) begin
        sh  <= sh << 1;
        cnt <= cnt - 1'b1;
      end else if (!empty) begin
        sh    <= mem[rptr[AW-1:0]];
        cnt   <= BCW'(DW);
        rptr  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end else begin
        if (cnt == BCW'(1)) udf <= 1'b1;
        cnt <= '0;
      end
    end

  assign ser_out      = enable && (cnt != '0) && sh[DW-1];
  assign vco_down     = enable && below;
  assign vco_up       = enable && !below && above;
  assign fifo_corrupt = ovf | udf;
endmodule

// File: rtl/elastic_fifo_steer_chk.sv
module elastic_fifo_steer_chk #(
  parameter int PW = 6
) (
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_rst_n,
  input logic          enable,
  input logic          ser_out,
  input logic          vco_up,
  input logic          vco_down,
  input logic          fifo_corrupt,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  localparam logic [PW-1:0] CAP = PW'(1 << (PW - 1));

  AST_STEER_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    !(vco_up && vco_down)); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    !enable |-> (!ser_out && !vco_up && !vco_down)); // R4
  AST_CORRUPT_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    fifo_corrupt |=> fifo_corrupt); // R9
  AST_NO_OVERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    (wptr - rptr) <= CAP); // R1
  AST_READ_HOLDS_OFF: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    !enable |=> $stable(rptr)); // R4
endmodule

bind elastic_fifo_steer elastic_fifo_steer_chk #(.PW(AW + 1)) u_chk (
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .wr_rst_n(wr_rst_n), .enable(enable),
  .ser_out(ser_out), .vco_up(vco_up), .vco_down(vco_down),
  .fifo_corrupt(fifo_corrupt), .wptr(wptr), .rptr(rptr));

// File: tb/test_elastic_fifo_steer.sv
module test_elastic_fifo_steer;
  logic clk = 0, rst_n = 0, wr_clk_en = 0, wr_valid = 0, enable = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] hi_mark = 0, lo_mark = 0;
  logic ser_out, vco_up, vco_down, fifo_corrupt;

  always #10 clk = ~clk;

  elastic_fifo_steer i_elastic_fifo_steer (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_clk_en(wr_clk_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_clk(clk), .rd_rst_n(rst_n), .enable(enable),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .ser_out(ser_out), .vco_up(vco_up),
    .vco_down(vco_down), .fifo_corrupt(fifo_corrupt));

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R9";

  // reference model: counts, a data queue and the two-stage pointer view
  byte unsigned q[$];
  int wp, rp, ws1, ws2, rs1, rs2, cnt, ovf, udf;
  logic [7:0] sh;

  always @(posedge clk) begin
    int nwp, nrp, nws1, nws2, nrs1, nrs2, ncnt;
    logic [7:0] nsh;
    cyc++;
    if (!rst_n) begin
      q.delete(); wp = 0; rp = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
      cnt = 0; sh = 0; ovf = 0; udf = 0;
    end else begin
      nwp = wp; nrp = rp; nsh = sh; ncnt = cnt;
      if (wr_clk_en && wr_valid) begin
        if (wp - rs2 == 32) ovf = 1;
        else begin q.push_back(wr_data); nwp = wp + 1; end
      end
      if (!enable) begin nsh = 0; ncnt = 0; end
      else if (cnt > 1) begin nsh = sh << 1; ncnt = cnt - 1; end
      else if (ws2 != rp) begin nsh = q.pop_front(); ncnt = 8; nrp = rp + 1; end
      else begin if (cnt == 1) udf = 1; ncnt = 0; end
      nws2 = ws1; nws1 = wp; nrs2 = rs1; nrs1 = rp;
      wp = nwp; rp = nrp; sh = nsh; cnt = ncnt;
      ws1 = nws1; ws2 = nws2; rs1 = nrs1; rs2 = nrs2;
    end
  end

  task automatic check1(string sig, logic got, logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", tag, sig, cyc, got, exp);
    end
  endtask

  task automatic compare_all();
    int fill;
    logic e_down, e_up;
    fill = ws2 - rp;
    e_down = enable && (fill < int'(lo_mark));
    e_up = enable && !e_down && (fill > int'(hi_mark));
    check1("ser_out", ser_out, enable && cnt != 0 && sh[7]);
    check1("vco_down", vco_down, e_down);
    check1("vco_up", vco_up, e_up);
    check1("fifo_corrupt", fifo_corrupt, logic'(ovf | udf));
  endtask

  // mode 0: no writes, 1: every edge, 2: enable 1 in 3 with valid dropouts, 3: enable 1 in 12
  task automatic run(int n, int mode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      wr_data = 8'(cyc * 37 + 5);
      case (mode)
        1: begin wr_clk_en = 1; wr_valid = 1; end
        2: begin wr_clk_en = (cyc % 3 == 0); wr_valid = (cyc % 7 != 0); end
        3: begin wr_clk_en = (cyc % 12 == 0); wr_valid = 1; end
        default: begin wr_clk_en = (cyc % 2 == 0); wr_valid = 0; end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_clk_en = 0; wr_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    tag = "R9"; run(3, 0);                    // reset state
    tag = "R10 R4"; run(12, 1); run(10, 0);   // written while disabled, output quiet
    hi_mark = 8; lo_mark = 4; enable = 1;
    tag = "R11 R2"; run(100, 0);              // first byte latency, back-to-back drain
    tag = "R3 R6"; run(300, 3);               // sparse writes: gaps, underflow, slow request
    do_reset();
    hi_mark = 20; lo_mark = 2;
    tag = "R1 R5 R8"; run(450, 2);            // filling past high mark into overflow
    tag = "R9"; run(350, 0);                  // drain: flag stays set
    do_reset();
    hi_mark = 0; lo_mark = 31;
    tag = "R7"; run(16, 1); run(60, 0);       // overlapping marks
    do_reset();
    hi_mark = 10; lo_mark = 1;
    tag = "R2 R4"; run(13, 1);
    enable = 0; run(5, 0);                    // disabled mid byte
    enable = 1; run(150, 0);                  // resumes with next byte
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #4ms;
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule